// File: doc/BRIEF.md
# Single-Wire Serial Bus Master

This block is the master side of a half-duplex serial line that uses a single wire. Software works it through a small bank of byte-wide registers. To run a transfer, software sets a start bit in the control register, and two mode bits pick the transfer type. The transfer is a break pulse that wakes the slave, a byte sent out bit by bit as timed low pulses, or a byte read in from low pulses that the slave drives. When the transfer ends, one of three sticky status flags is set. The start bit clears itself, and an interrupt line rises while interrupts are enabled.

The line is open drain. The block only asserts a pull-low enable and observes the wire level. Every bit slot, pulse width, sample point and response window is measured in clock cycles and set by a parameter. A soft reset, started through the system configuration register, returns every register and the bit engine to their reset state for a set number of cycles. A status bit shows when the reset has finished.

The interrupt enable bit also acts as a gate. While it is clear, a finished transfer waits without setting a flag or clearing its start bit, and reads of the status register leave the flags in place.

Top module: `swire_master`

## Requirements
- R1: A read of offset 0x00 returns the constant byte {REV_MAJOR, REV_MINOR}, with the major number in bits 7:4 and the minor number in bits 3:0. With the default parameters this is 0x21.
- R2: Writing offset 0x0C with bit4 (start) = 1, bit1 (direction) = 0 and bit2 (break) = 0 sends the byte held at offset 0x04, least significant bit first. Each bit slot is BIT_CYC cycles long. The line is pulled low for ONE_LOW cycles for a 1 and for ZERO_LOW cycles for a 0. At the end, interrupt-status bit2 is set and the start bit reads 0.
- R3: A start with direction = 1 captures eight bits from the slave, least significant bit first. Each bit is the line level SAMPLE_CYC cycles after the slave's falling edge. The byte goes to offset 0x08, interrupt-status bit1 is set and the start bit clears. The direction bit keeps its value.
- R4: A start with bit2 (break) = 1 pulls the line low for BRK_LOW cycles and then releases it for BRK_REL cycles. It then sets interrupt-status bit0, and both the start bit and the break bit clear.
- R5: During a read, if no falling edge appears within WAIT_CYC cycles of waiting, the transfer ends with interrupt-status bit0 set and bit1 clear.
- R6: While bit6 (interrupt enable) of offset 0x0C is 1, a read of offset 0x10 returns the flags and clears all three.
- R7: While interrupt enable is 0, a finished transfer holds with its start bit at 1 and sets no flag. Reads of offset 0x10 do not clear the flags. The transfer finishes once interrupt enable is set.
- R8: The irq output is 1 exactly when interrupt enable is 1 and at least one status flag is set.
- R9: Writing bit1 = 1 to offset 0x14 starts a soft reset. For RST_CYC cycles, bit0 of offset 0x18 reads 0. Afterwards it reads 1 and all registers hold their reset values, with the control register and the transmit data at 0. After a power-on reset, bit0 of offset 0x18 reads 1.
- R10: Bit0 of offset 0x14 is stored and read back, and it has no other effect.
- R11: When a flag is set in the same cycle as a clearing read of offset 0x10, the flag stays set. The read itself returns the value from before that cycle.
- R12: The line pull-low enable is 0 whenever no transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a read has side effects at offset 0x10 |
| regAddr | input | 5 | Byte offset of the register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid in the same cycle as regRdEn |
| lineIn | input | 1 | Sampled level of the bus wire |
| lineDriveLow | output | 1 | Open-drain pull-low enable |
| irq | output | 1 | Interrupt request |

## Verification
Two actions can fall in the same cycle: the end of a transfer setting its flag, and a status read clearing the flags. The bench provokes this with a transmit started while interrupt enable is 0. It then writes interrupt enable in one cycle and reads the status register in the very next cycle, which is the cycle in which the held transfer finishes. That read must return 0, and a later read, taken with interrupts disabled, must still show the transmit flag. Together these prove that the set took priority over the clear.

// File: rtl/swire_pkg.sv
package swire_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_BREAK = 2'd2
  } opKind_t;

  typedef enum logic [1:0] {
    RES_TX = 2'd0,
    RES_RX = 2'd1,
    RES_TO = 2'd2
  } resKind_t;

  // strobes from the bit engine to the register datapath
  typedef struct packed {
    logic finish;
    logic flagTx;
    logic flagRx;
    logic flagTo;
    logic rxShift;
    logic rxBit;
  } ctrlStrobe_t;

  localparam logic [4:0] OFS_REV     = 5'h00;
  localparam logic [4:0] OFS_TXD     = 5'h04;
  localparam logic [4:0] OFS_RXD     = 5'h08;
  localparam logic [4:0] OFS_CTRL    = 5'h0C;
  localparam logic [4:0] OFS_ISTAT   = 5'h10;
  localparam logic [4:0] OFS_SYSCFG  = 5'h14;
  localparam logic [4:0] OFS_SYSSTAT = 5'h18;

  localparam int B_MODE  = 0;
  localparam int B_DIR   = 1;
  localparam int B_BRK   = 2;
  localparam int B_START = 4;
  localparam int B_CLKEN = 5;
  localparam int B_IE    = 6;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/swire_regs.sv
module swire_regs
  import swire_pkg::*;
#(
  parameter int REV_MAJOR = 2,
  parameter int REV_MINOR = 1,
  parameter int RST_CYC   = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [4:0]  regAddr,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  ctrlStrobe_t strobe,
  output logic        start,
  output opKind_t     opKind,
  output logic        ieBit,
  output logic        goBit,
  output logic [7:0]  txByte,
  output logic [2:0]  flags,
  output logic        resetting,
  output logic        irq
);

  localparam int RC_W = $clog2(RST_CYC + 1);
  localparam logic [7:0] REV_BYTE = {4'(REV_MAJOR), 4'(REV_MINOR)};

  logic [RC_W-1:0] rstCnt;
  logic [7:0] rxByte;
  logic modeBit, dirBit, brkBit, clkEnBit, autoIdle;
  logic wrCtrl, wrSys, statClr;
  logic [2:0] flagSet;

  assign wrCtrl  = regWrEn && (regAddr == OFS_CTRL) && !resetting;
  assign wrSys   = regWrEn && (regAddr == OFS_SYSCFG) && !resetting;
  assign start   = wrCtrl && !goBit && regWrData[B_START];
  assign statClr = regRdEn && (regAddr == OFS_ISTAT) && ieBit && !resetting;
  assign flagSet = {strobe.flagTx, strobe.flagRx, strobe.flagTo};
  assign resetting = (rstCnt != '0);

  always_comb begin
    if (regWrData[B_BRK])      opKind = OP_BREAK;
    else if (regWrData[B_DIR]) opKind = OP_READ;
    else                       opKind = OP_WRITE;
  end

  // soft reset counter
  always_ff @(posedge clk) begin
    if (!rstN) rstCnt <= '0;
    else if (wrSys && regWrData[1]) rstCnt <= RC_W'(RST_CYC);
    else if (resetting) rstCnt <= rstCnt - 1'b1;
  end

  // control register
  always_ff @(posedge clk) begin
    if (!rstN || resetting) begin
      modeBit  <= 1'b0;
      dirBit   <= 1'b0;
      brkBit   <= 1'b0;
      goBit    <= 1'b0;
      clkEnBit <= 1'b0;
      ieBit    <= 1'b0;
    end else begin
      if (wrCtrl) begin
        modeBit  <= regWrData[B_MODE];
        clkEnBit <= regWrData[B_CLKEN];
        ieBit    <= regWrData[B_IE];
        if (!goBit) begin
          dirBit <= regWrData[B_DIR];
          brkBit <= regWrData[B_BRK];
          goBit  <= regWrData[B_START];
        end
      end
      if (strobe.finish) begin
        goBit  <= 1'b0;
        brkBit <= 1'b0;
      end
    end
  end

  // data registers and system config
  always_ff @(posedge clk) begin
    if (!rstN || resetting) begin
      txByte   <= '0;
      rxByte   <= '0;
      autoIdle <= 1'b0;
    end else begin
      if (regWrEn && regAddr == OFS_TXD) txByte <= regWrData;
      if (wrSys) autoIdle <= regWrData[0];
      if (strobe.rxShift) rxByte <= {strobe.rxBit, rxByte[7:1]};
    end
  end

  // sticky flags: a set beats a clearing read
  for (genvar i = 0; i < 3; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rstN || resetting) flags[i] <= 1'b0;
      else flags[i] <= (flags[i] && !statClr) || flagSet[i];
    end
  end

  assign irq = ieBit && (|flags);

  always_comb begin
    regRdData = '0;
    if (regRdEn) begin
      unique case (regAddr)
        OFS_REV:     regRdData = REV_BYTE;
        OFS_TXD:     regRdData = txByte;
        OFS_RXD:     regRdData = rxByte;
        OFS_CTRL:    regRdData = {1'b0, ieBit, clkEnBit, goBit, 1'b0, brkBit, dirBit, modeBit};
        OFS_ISTAT:   regRdData = {5'b0, flags[2], flags[1], flags[0]};
        OFS_SYSCFG:  regRdData = {6'b0, resetting, autoIdle};
        OFS_SYSSTAT: regRdData = {7'b0, !resetting};
        default:     regRdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/swire_ctrl.sv
module swire_ctrl
  import swire_pkg::*;
#(
  parameter int BIT_CYC    = 40,
  parameter int ONE_LOW    = 8,
  parameter int ZERO_LOW   = 24,
  parameter int BRK_LOW    = 60,
  parameter int BRK_REL    = 20,
  parameter int WAIT_CYC   = 100,
  parameter int SAMPLE_CYC = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        softRst,
  input  logic        start,
  input  opKind_t     opKind,
  input  logic        ieBit,
  input  logic [7:0]  txByte,
  input  logic        lineIn,
  output logic        lineDriveLow,
  output logic        busy,
  output ctrlStrobe_t strobe
);

  localparam int MAXC = maxOf(maxOf(maxOf(BIT_CYC, BRK_LOW), maxOf(BRK_REL, WAIT_CYC)),
                              maxOf(SAMPLE_CYC, maxOf(ONE_LOW, ZERO_LOW)));
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_BRK_LOW, S_BRK_REL, S_WR_LOW, S_WR_REL,
    S_RD_WAIT, S_RD_SAMP, S_RD_HIGH, S_DONE
  } state_t;

  state_t state;
  logic [CNT_W-1:0] cnt;
  logic [2:0] bitIdx;
  resKind_t res;
  logic [CNT_W-1:0] lowLen;

  assign lowLen = txByte[bitIdx] ? CNT_W'(ONE_LOW) : CNT_W'(ZERO_LOW);

  always_ff @(posedge clk) begin
    if (!rstN || softRst) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
      res    <= RES_TX;
    end else begin
      unique case (state)
        S_IDLE: begin
          cnt    <= '0;
          bitIdx <= '0;
          if (start) begin
            unique case (opKind)
              OP_BREAK: state <= S_BRK_LOW;
              OP_READ:  state <= S_RD_WAIT;
              default:  state <= S_WR_LOW;
            endcase
          end
        end
        S_BRK_LOW: begin
          if (cnt == CNT_W'(BRK_LOW - 1)) begin
            state <= S_BRK_REL;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_BRK_REL: begin
          if (cnt == CNT_W'(BRK_REL - 1)) begin
            state <= S_DONE;
            res   <= RES_TO;
          end else cnt <= cnt + 1'b1;
        end
        S_WR_LOW: begin
          if (cnt == lowLen - 1'b1) state <= S_WR_REL;
          cnt <= cnt + 1'b1;
        end
        S_WR_REL: begin
          if (cnt == CNT_W'(BIT_CYC - 1)) begin
            cnt <= '0;
            if (bitIdx == 3'd7) begin
              state <= S_DONE;
              res   <= RES_TX;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= S_WR_LOW;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_RD_WAIT: begin
          if (!lineIn) begin
            state <= S_RD_SAMP;
            cnt   <= '0;
          end else if (cnt == CNT_W'(WAIT_CYC - 1)) begin
            state <= S_DONE;
            res   <= RES_TO;
          end else cnt <= cnt + 1'b1;
        end
        S_RD_SAMP: begin
          if (cnt == CNT_W'(SAMPLE_CYC - 1)) begin
            state <= S_RD_HIGH;
            cnt   <= '0;
          end else cnt <= cnt + 1'b1;
        end
        S_RD_HIGH: begin
          if (lineIn) begin
            cnt <= '0;
            if (bitIdx == 3'd7) begin
              state <= S_DONE;
              res   <= RES_RX;
            end else begin
              bitIdx <= bitIdx + 1'b1;
              state  <= S_RD_WAIT;
            end
          end else if (cnt == CNT_W'(WAIT_CYC - 1)) begin
            state <= S_DONE;
            res   <= RES_TO;
          end else cnt <= cnt + 1'b1;
        end
        S_DONE: if (ieBit) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy         = (state != S_IDLE);
  assign lineDriveLow = (state == S_BRK_LOW) || (state == S_WR_LOW);

  always_comb begin
    strobe         = '0;
    strobe.finish  = (state == S_DONE) && ieBit;
    strobe.flagTx  = strobe.finish && (res == RES_TX);
    strobe.flagRx  = strobe.finish && (res == RES_RX);
    strobe.flagTo  = strobe.finish && (res == RES_TO);
    strobe.rxShift = (state == S_RD_SAMP) && (cnt == CNT_W'(SAMPLE_CYC - 1));
    strobe.rxBit   = lineIn;
  end

endmodule

// File: rtl/swire_master.sv
module swire_master
  import swire_pkg::*;
#(
  parameter int REV_MAJOR  = 2,
  parameter int REV_MINOR  = 1,
  parameter int RST_CYC    = 8,
  parameter int BIT_CYC    = 40,
  parameter int ONE_LOW    = 8,
  parameter int ZERO_LOW   = 24,
  parameter int BRK_LOW    = 60,
  parameter int BRK_REL    = 20,
  parameter int WAIT_CYC   = 100,
  parameter int SAMPLE_CYC = 12
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWrEn,
  input  logic       regRdEn,
  input  logic [4:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       lineIn,
  output logic       lineDriveLow,
  output logic       irq
);

  ctrlStrobe_t strobe;
  opKind_t opKind;
  logic start, ieBit, goBit, resetting, busy;
  logic [7:0] txByte;
  logic [2:0] flags;

  swire_regs #(
    .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR), .RST_CYC(RST_CYC)
  ) iRegs (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .strobe(strobe), .start(start), .opKind(opKind), .ieBit(ieBit),
    .goBit(goBit), .txByte(txByte), .flags(flags), .resetting(resetting),
    .irq(irq)
  );

  swire_ctrl #(
    .BIT_CYC(BIT_CYC), .ONE_LOW(ONE_LOW), .ZERO_LOW(ZERO_LOW),
    .BRK_LOW(BRK_LOW), .BRK_REL(BRK_REL), .WAIT_CYC(WAIT_CYC),
    .SAMPLE_CYC(SAMPLE_CYC)
  ) iCtrl (
    .clk(clk), .rstN(rstN), .softRst(resetting), .start(start),
    .opKind(opKind), .ieBit(ieBit), .txByte(txByte), .lineIn(lineIn),
    .lineDriveLow(lineDriveLow), .busy(busy), .strobe(strobe)
  );

endmodule

// File: rtl/swire_checker.sv
module swire_checker
  import swire_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        lineDriveLow,
  input logic        goBit,
  input logic        ieBit,
  input logic        resetting,
  input logic        statRead,
  input logic [2:0]  flags,
  input ctrlStrobe_t strobe
);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !lineDriveLow);

  // R2
  go_self_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> !goBit);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN || resetting)
    (goBit && !ieBit) |=> goBit);

  // R11
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN || resetting)
    strobe.flagTx |=> flags[2]);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rstN || resetting)
    (statRead && ieBit && !strobe.finish) |=> (flags == 3'b000));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetting |=> !busy);

endmodule

bind swire_master swire_checker iChk (
  .clk(clk), .rstN(rstN), .busy(busy), .lineDriveLow(lineDriveLow),
  .goBit(goBit), .ieBit(ieBit), .resetting(resetting),
  .statRead(regRdEn && (regAddr == 5'h10)), .flags(flags), .strobe(strobe)
);

// File: tb/test_swire_master.sv
module test_swire_master;

  localparam int ONE_LOW  = 8;
  localparam int ZERO_LOW = 24;
  localparam int BRK_LOW  = 60;
  localparam int RST_CYC  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic lineDriveLow, irq, lineIn;
  logic slaveLow = 1'b0;
  int checks = 0, errors = 0;

  assign lineIn = !(lineDriveLow || slaveLow);

  always #10 clk = !clk;

  swire_master i_swire_master (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .lineIn(lineIn), .lineDriveLow(lineDriveLow), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      busRead(5'h0C, v);
      if (!v[4]) break;
    end
  endtask

  task automatic measureLow(output int w);
    w = 0;
    while (!lineDriveLow) @(negedge clk);
    while (lineDriveLow) begin w++; @(negedge clk); end
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R12 idle line", lineDriveLow, 0);
    check("R8 irq after reset", irq, 0);
    busRead(5'h0C, v); check("R9 ctrl reset", v, 8'h00);
    busRead(5'h10, v); check("R9 status reset", v, 8'h00);
    busRead(5'h18, v); check("R9 reset done after power-on", v, 8'h01);
  endtask

  task automatic testRevision();
    logic [7:0] v;
    busRead(5'h00, v); check("R1 revision", v, 8'h21);
  endtask

  task automatic testAutoIdle();
    logic [7:0] v;
    busWrite(5'h14, 8'h01);
    busRead(5'h14, v); check("R10 auto-idle readback", v, 8'h01);
    busRead(5'h18, v); check("R10 no reset side effect", v, 8'h01);
    check("R10 line untouched", lineDriveLow, 0);
  endtask

  task automatic testBreak();
    logic [7:0] v;
    int w;
    fork
      busWrite(5'h0C, 8'h54);
      measureLow(w);
    join
    check("R4 break low width", w, BRK_LOW);
    waitIdle();
    check("R8 irq after break", irq, 1);
    busRead(5'h10, v); check("R4 timeout flag", v, 8'h01);
    busRead(5'h0C, v); check("R4 start and break cleared", v, 8'h40);
    check("R6 irq cleared by read", irq, 0);
  endtask

  task automatic testWrite(input logic [7:0] b);
    logic [7:0] v;
    int w [8];
    busWrite(5'h04, b);
    fork
      busWrite(5'h0C, 8'h50);
      for (int i = 0; i < 8; i++) measureLow(w[i]);
    join
    for (int i = 0; i < 8; i++)
      check("R2 bit pulse width", w[i], b[i] ? ONE_LOW : ZERO_LOW);
    waitIdle();
    busRead(5'h10, v); check("R2 tx complete flag", v, 8'h04);
    busRead(5'h10, v); check("R6 flags cleared", v, 8'h00);
  endtask

  task automatic slaveSend(input logic [7:0] b);
    repeat (6) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      slaveLow = 1'b1;
      repeat (b[i] ? 5 : 24) @(negedge clk);
      slaveLow = 1'b0;
      repeat (15) @(negedge clk);
    end
  endtask

  task automatic testRead(input logic [7:0] b);
    logic [7:0] v;
    fork
      busWrite(5'h0C, 8'h42 | 8'h10);
      slaveSend(b);
    join
    waitIdle();
    busRead(5'h08, v); check("R3 received byte", v, b);
    busRead(5'h10, v); check("R3 rx complete flag", v, 8'h02);
    busRead(5'h0C, v); check("R3 start cleared", v, 8'h42);
  endtask

  task automatic testReadTimeout();
    logic [7:0] v;
    busWrite(5'h0C, 8'h52);
    waitIdle();
    busRead(5'h10, v); check("R5 timeout without rx", v, 8'h01);
  endtask

  task automatic testStallAndCollision();
    logic [7:0] v;
    busWrite(5'h04, 8'hF0);
    busWrite(5'h0C, 8'h10);
    repeat (1000) @(negedge clk);
    busRead(5'h0C, v); check("R7 start held", v, 8'h10);
    busRead(5'h10, v); check("R7 no flag while held", v, 8'h00);
    check("R8 irq low while held", irq, 0);
    // enable in one cycle, read status in the next (finish cycle)
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 5'h0C; regWrData = 8'h40;
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b1; regAddr = 5'h10;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
    check("R11 read returns old value", v, 8'h00);
    busWrite(5'h0C, 8'h00);
    busRead(5'h10, v); check("R11 set wins over clear", v, 8'h04);
    busRead(5'h10, v); check("R7 read does not clear", v, 8'h04);
    check("R8 irq gated by enable", irq, 0);
    busWrite(5'h0C, 8'h40);
    @(negedge clk);
    check("R8 irq with enable", irq, 1);
    busRead(5'h10, v);
    busRead(5'h10, v); check("R6 cleared once enabled", v, 8'h00);
  endtask

  task automatic testSoftReset();
    logic [7:0] v;
    busWrite(5'h04, 8'h77);
    busWrite(5'h14, 8'h02);
    busRead(5'h18, v); check("R9 reset in progress", v, 8'h00);
    repeat (RST_CYC + 2) @(negedge clk);
    busRead(5'h18, v); check("R9 reset done", v, 8'h01);
    busRead(5'h04, v); check("R9 tx cleared", v, 8'h00);
    busRead(5'h0C, v); check("R9 ctrl cleared", v, 8'h00);
    check("R12 line idle after reset", lineDriveLow, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRevision();
    testAutoIdle();
    busWrite(5'h0C, 8'h40);
    testBreak();
    testWrite(8'hA5);
    testWrite(8'h3C);
    testRead(8'h3C);
    testRead(8'hC9);
    testReadTimeout();
    testStallAndCollision();
    testSoftReset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule